// File: doc/BRIEF.md
# PLL Control Register with Enable/Select Interlock

This block is a byte-wide control and status register for a clock generator. It sits on a simple CPU register bus with a select, a read strobe, a write strobe and separate write and read data. It holds three live bits. The first is a sticky lock-change flag that records any change in the PLL lock condition. The second is a PLL enable bit, driven out as `pll_enable`. The third is a base-clock select bit, driven out as `clock_select`: 0 picks the crystal clock and 1 picks the VCO clock.

The enable and select bits guard each other, so the output clock can never be taken from a stopped PLL. Select can only be set while the PLL is already running, and enable cannot be dropped while the VCO is selected. Both rules are checked against the register contents held before the write. As a result, moving from PLL-off to VCO-selected takes two writes: one to enable the PLL and one to select the VCO.

The lock-change flag is cleared by any read. This includes the read half of a read-modify-write. The flag only records events while automatic bandwidth mode is inactive.

Top module: `pllctl_reg`

## Requirements
- R1: Reset is synchronous and active-low. After reset the flag is 0, enable is 1 and select is 0. A read then returns 0x4F, with `pll_enable`=1 and `clock_select`=0.
- R2: The read byte layout is: bit 7 = lock-change flag, bit 6 = enable, bit 5 = select, bit 4 = 0, bits 3:0 = 1. A `lock_evt` pulse while `auto_bw`=0 sets the flag at the next clock edge.
- R3: While `auto_bw`=1, `lock_evt` pulses do not set the flag.
- R4: A read (`bus_sel` and `bus_rd` both high) returns the flag's current value in that same cycle. It clears the flag at the clock edge that ends the read.
- R5: If a `lock_evt` pulse that is counted and a read fall in the same cycle, the flag is 1 after that edge.
- R6: Bit 7 is read-only. Writing it as 1 does not set the flag, and writing it as 0 does not clear it.
- R7: A write with bit 6 = 0 leaves enable at 1 if select was 1 before the write.
- R8: A write with bit 5 = 1 sets select only if enable was 1 before the write and stays 1 after it. From enable=0, writing 0x60 gives enable=1 and select=0. A second 0x60 then gives select=1. From enable=1/select=0, writing 0x20 gives enable=0 and select=0.
- R9: Writes to bits 4:0 have no effect. Reads always show bit 4 = 0 and bits 3:0 = 1111.
- R10: `pll_enable` and `clock_select` follow the stored bits one edge after a write. `clock_select`=1 with `pll_enable`=0 never occurs.
- R11: Strobes with `bus_sel`=0 change no state, and `bus_rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Address decode hit for this register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| lock_evt | input | 1 | One-cycle pulse on a PLL lock change |
| auto_bw | input | 1 | Automatic bandwidth mode active; blocks flag recording |
| pll_enable | output | 1 | PLL run enable |
| clock_select | output | 1 | Base clock source: 1 = VCO, 0 = crystal |

## Verification
Read data is combinational, so it must be sampled inside the read cycle, before the edge that clears the flag. The flag, enable and select each change one edge after the write, event or read that causes them. The bench therefore drives every access on a falling edge and samples read data 1 ns later. It checks the outputs and the next read only after the following falling edge. This ensures that each comparison sees exactly one register update past its stimulus. The same-cycle event/read case is checked both in the read data and in the follow-up read.

// File: rtl/pllctl_pkg.sv
// Shared field positions and types for the PLL control register.
// Assumes a byte-wide bus; field positions are part of the software view.
package pllctl_pkg;
    localparam int DATA_W   = 8;
    localparam int BIT_FLAG = 7;
    localparam int BIT_EN   = 6;
    localparam int BIT_SEL  = 5;
    localparam int BIT_GAP  = 4;
    localparam int FILL_W   = 4;

    typedef struct packed {
        logic en;
        logic sel;
    } ctrl_t;
endpackage

// File: rtl/pllctl_decode.sv
// Bus access decode: qualifies strobes with the select and extracts the
// two writable control bits. Assumes strobes are single-cycle per access.
module pllctl_decode
    import pllctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         bus_sel,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic         rd_hit,
    output logic         wr_hit,
    output ctrl_t        wr_req
);
    // Bits without a writable function are gathered here on purpose.
    logic unused_wdata_bits;

    // Qualify strobes and pick out requested control values.
    always_comb begin
        rd_hit     = bus_sel & bus_rd;
        wr_hit     = bus_sel & bus_wr;
        wr_req.en  = bus_wdata[BIT_EN];
        wr_req.sel = bus_wdata[BIT_SEL];
    end

    assign unused_wdata_bits = ^{bus_wdata[BIT_FLAG], bus_wdata[BIT_GAP:0]};
endmodule

// File: rtl/pllctl_flag.sv
// Sticky lock-change flag. Set by a lock event when automatic bandwidth
// mode is off; cleared by a read. A same-cycle event wins over the clear.
module pllctl_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_evt,
    input  logic auto_bw,
    input  logic rd_hit,
    output logic flag_q
);
    logic evt_counted;

    // Decide whether this cycle's event is recorded.
    always_comb evt_counted = lock_evt & ~auto_bw;

    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag_q <= 1'b0;
        else if (evt_counted) flag_q <= 1'b1;
        else if (rd_hit)      flag_q <= 1'b0;
    end
endmodule

// File: rtl/pllctl_ctrl.sv
// Interlocked enable/select pair. Both guards use the contents held before
// the write; select is also refused when the same write drops enable.
module pllctl_ctrl
    import pllctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  ctrl_t wr_req,
    output ctrl_t ctrl_q
);
    ctrl_t ctrl_d;

    // Apply the write under the interlock rules.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) begin
            ctrl_d.en  = wr_req.en | ctrl_q.sel;
            ctrl_d.sel = wr_req.sel & ctrl_q.en & ctrl_d.en;
        end
    end

    // Register the pair; reset runs the PLL with the crystal selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.en  <= 1'b1;
            ctrl_q.sel <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/pllctl_reg.sv
// Top of the PLL control register: decode, sticky flag, interlocked
// control bits and the read-back mux. Read data is combinational.
module pllctl_reg
    import pllctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         lock_evt,
    input  logic         auto_bw,
    output logic         pll_enable,
    output logic         clock_select
);
    logic         rd_hit;
    logic         wr_hit;
    ctrl_t        wr_req;
    ctrl_t        ctrl_q;
    logic         flag_q;
    logic [W-1:0] view;

    pllctl_decode #(.W(W)) u_dec (
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit),
        .wr_req    (wr_req)
    );

    pllctl_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_evt (lock_evt),
        .auto_bw  (auto_bw),
        .rd_hit   (rd_hit),
        .flag_q   (flag_q)
    );

    pllctl_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wr_req (wr_req),
        .ctrl_q (ctrl_q)
    );

    // Unimplemented low bits read as ones.
    for (genvar i = 0; i < FILL_W; i++) begin : g_fill
        assign view[i] = 1'b1;
    end
    assign view[BIT_GAP]  = 1'b0;
    assign view[BIT_SEL]  = ctrl_q.sel;
    assign view[BIT_EN]   = ctrl_q.en;
    assign view[BIT_FLAG] = flag_q;

    // Drive read data only during a read.
    always_comb bus_rdata = rd_hit ? view : '0;

    // Mirror the control bits to the clock generator.
    always_comb begin
        pll_enable   = ctrl_q.en;
        clock_select = ctrl_q.sel;
    end
endmodule

// File: rtl/pllctl_reg_chk.sv
// Property checker for pllctl_reg, attached by bind below.
module pllctl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       lock_evt,
    input logic       auto_bw,
    input logic       pll_enable,
    input logic       clock_select,
    input logic       flag_q
);
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_evt && !auto_bw) |=> flag_q);

    p_auto_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && (!lock_evt || auto_bw)) |=> !flag_q);

    p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && bus_sel && bus_rd && !(lock_evt && !auto_bw)) |=> !flag_q);

    p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clock_select && bus_sel && bus_wr) |=> pll_enable);

    p_sel_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_enable && !clock_select) |=> !clock_select);

    p_fill_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd) |-> (bus_rdata[4:0] == 5'h0F));

    p_sel_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clock_select |-> pll_enable);

    p_nosel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> ($stable(pll_enable) && $stable(clock_select)));
endmodule

bind pllctl_reg pllctl_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_rdata    (bus_rdata),
    .lock_evt     (lock_evt),
    .auto_bw      (auto_bw),
    .pll_enable   (pll_enable),
    .clock_select (clock_select),
    .flag_q       (flag_q)
);

// File: tb/pllctl_reg_tb_top.sv
// Directed bench for pllctl_reg: one task per scenario.
module pllctl_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       lock_evt = 1'b0;
    logic       auto_bw = 1'b0;
    logic       pll_enable;
    logic       clock_select;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pllctl_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .lock_evt     (lock_evt),
        .auto_bw      (auto_bw),
        .pll_enable   (pll_enable),
        .clock_select (clock_select)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic en, input logic sel);
        chk(req, {6'd0, pll_enable, clock_select}, {6'd0, en, sel});
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic bus_read(output logic [7:0] d, input logic with_evt);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; lock_evt = with_evt;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0; lock_evt = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        lock_evt = 1'b1;
        @(negedge clk);
        lock_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk_out("R1 outputs after reset", 1'b1, 1'b0);
        chk("R11 rdata idle", bus_rdata, 8'h00);
        bus_read(d, 1'b0);
        chk("R1 reset read", d, 8'h4F);
    endtask

    task automatic t_flag();
        logic [7:0] d;
        pulse_evt();
        bus_read(d, 1'b0);
        chk("R2 flag set by event", d, 8'hCF);
        bus_read(d, 1'b0);
        chk("R4 flag cleared by read", d, 8'h4F);
    endtask

    task automatic t_auto();
        logic [7:0] d;
        auto_bw = 1'b1;
        pulse_evt();
        pulse_evt();
        auto_bw = 1'b0;
        bus_read(d, 1'b0);
        chk("R3 auto mode blocks flag", d, 8'h4F);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        pulse_evt();
        bus_read(d, 1'b1);
        chk("R5 read data in collision", d, 8'hCF);
        bus_read(d, 1'b0);
        chk("R5 flag kept after collision", d, 8'hCF);
        bus_read(d, 1'b0);
        chk("R4 flag cleared after second read", d, 8'h4F);
    endtask

    task automatic t_flag_ro();
        logic [7:0] d;
        bus_write(8'hC0);
        bus_read(d, 1'b0);
        chk("R6 write 1 to flag ignored", d, 8'h4F);
        pulse_evt();
        bus_write(8'h40);
        bus_read(d, 1'b0);
        chk("R6 write 0 to flag ignored", d, 8'hCF);
    endtask

    task automatic t_interlock();
        logic [7:0] d;
        bus_write(8'h00);
        chk_out("R10 enable cleared", 1'b0, 1'b0);
        bus_write(8'h20);
        chk_out("R8 select blocked while off", 1'b0, 1'b0);
        bus_write(8'h60);
        chk_out("R8 first write enables only", 1'b1, 1'b0);
        bus_write(8'h60);
        chk_out("R8 second write selects VCO", 1'b1, 1'b1);
        bus_read(d, 1'b0);
        chk("R10 read both set", d, 8'h6F);
        bus_write(8'h00);
        chk_out("R7 enable kept while selected", 1'b1, 1'b0);
        bus_write(8'h20);
        chk_out("R8 clear enable wins over select", 1'b0, 1'b0);
        bus_write(8'h40);
        chk_out("R10 re-enable", 1'b1, 1'b0);
    endtask

    task automatic t_fill();
        logic [7:0] d;
        bus_write(8'h50);
        bus_read(d, 1'b0);
        chk("R9 zero to fill bits ignored", d, 8'h4F);
        bus_write(8'h5F);
        bus_read(d, 1'b0);
        chk("R9 ones to gap bit ignored", d, 8'h4F);
    endtask

    task automatic t_nosel();
        logic [7:0] d;
        pulse_evt();
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
        #1 chk("R11 rdata zero without select", bus_rdata, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk_out("R11 control unchanged", 1'b1, 1'b0);
        bus_read(d, 1'b0);
        chk("R11 flag kept without select", d, 8'hCF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flag();
        t_auto();
        t_collide();
        t_flag_ro();
        t_interlock();
        t_fill();
        t_nosel();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule